// File: doc/BRIEF.md
# SMBus Block Transfer Engine

This engine runs the block phases of a host-side SMBus controller. It covers three kinds of block transfer: the SMBus block write, the SMBus block read, and a raw I2C-style block read that sends a device offset and has no count byte. The engine does not toggle the bus wires. It issues one byte-level operation at a time (start, repeated start, write byte, read byte with ACK or NAK, stop) to a shared bus master that sits outside the block, and it waits for the master's done pulse before moving on.

There is no FIFO. A single block-data register carries every payload byte. Each time a data byte completes, the engine raises `byte_done_o` and then holds the bus until software clears it with `bd_clr_i`. In that window software loads the next byte to send or collects the byte just received. The engine keeps its own byte count. On a write it sends the count byte ahead of the data. On an SMBus read it captures the count byte that comes back from the target. A transfer ends when the count has been moved, or when software has raised `last_byte_i`, in which case the next byte read is NAKed and followed by a stop.

Top module: `smbblk_engine`

## Requirements
- R1: With `mode_i`=0 (SMBus block write), an accepted start issues these operations in order: START, WRITE {addr,0}, WRITE `cmd_i`, WRITE count (`dat0_i`), then one WRITE of the block-data register per data byte, then STOP, and sets `intr_o`. The operation codes on `m_op_o` are: 1 START, 2 repeated START, 3 WRITE, 4 READ, 5 STOP. `m_wdata_o` is 0 on any operation that is not a WRITE, and `m_nak_o` is 0 on any operation that is not a READ.
- R2: After each data byte completes (a written byte acknowledged, or a read byte received), `byte_done_o` rises. While it is high, no bus operation is requested. Pulsing `bd_clr_i` clears it, and the engine then continues.
- R3: With `mode_i`=1 (SMBus block read) the sequence is: START, WRITE {addr,0}, WRITE `cmd_i`, repeated START, WRITE {addr,1}, READ of the count byte with ACK, then one READ per counted byte, then STOP, and `intr_o` is set. Only the final counted byte is NAKed. The count byte appears on `count_o`, and each data byte appears on `blk_rdata_o` while `byte_done_o` is high.
- R4: If the received count byte is 0 or greater than MAXLEN, the engine issues STOP straight away, with no data reads. It sets `dev_err_o` and does not set `intr_o`.
- R5: With `mode_i`=2 (I2C block read) the sequence is: START, WRITE {addr,0}, WRITE `dat1_i` (the offset), repeated START, WRITE {addr,1}, then data READs with no count byte. The first read issued after `last_byte_i` has been pulsed is NAKed and followed by STOP. A pulse given before the start makes a one-byte read. The MAXLEN-th byte is always NAKed.
- R6: In an SMBus block read, pulsing `last_byte_i` during a handshake makes the next read the final, NAKed one, even if the count has not been reached.
- R7: A start is rejected when `mode_i`=3 (I2C block write), or when `mode_i`=0 and `dat0_i` is 0 or greater than MAXLEN. A rejected start sets `dev_err_o`, issues no bus operation, and leaves `busy_o` low.
- R8: A NAK (`m_ack_i`=0) on any written byte, whether address, command, offset, count or data, makes the engine issue STOP next. It then sets `dev_err_o`, clears `busy_o`, and leaves `intr_o` low.
- R9: A start pulse while `busy_o` is high is ignored.
- R10: After reset, `busy_o`, `intr_o`, `dev_err_o`, `byte_done_o` and `m_req_o` are low.
- R11: Every accepted or rejected start clears `intr_o` and `dev_err_o` before the new outcome is recorded. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| mode_i | input | 2 | 0 SMBus write, 1 SMBus read, 2 I2C read, 3 I2C write (rejected) |
| addr_i | input | 7 | Target address |
| cmd_i | input | 8 | SMBus command byte |
| dat0_i | input | 8 | Byte count for writes |
| dat1_i | input | 8 | Device offset for I2C read |
| blk_wr_i | input | 1 | Load block-data register |
| blk_wdata_i | input | 8 | Byte to load |
| bd_clr_i | input | 1 | Clear byte done |
| last_byte_i | input | 1 | Mark the next read as final |
| busy_o | output | 1 | Transfer in progress |
| intr_o | output | 1 | Transfer completed without error |
| dev_err_o | output | 1 | Transfer rejected or aborted |
| byte_done_o | output | 1 | Data byte handshake pending |
| blk_rdata_o | output | 8 | Block-data register |
| count_o | output | 8 | Loaded or received byte count |
| m_req_o | output | 1 | Bus operation request, held until done |
| m_op_o | output | 3 | Bus operation code |
| m_wdata_o | output | 8 | Byte to write |
| m_nak_o | output | 1 | NAK the byte being read |
| m_done_i | input | 1 | Bus operation complete pulse |
| m_ack_i | input | 1 | Target acknowledged written byte |
| m_rdata_i | input | 8 | Byte read from bus |

## Verification
The bench builds the engine with MAXLEN = 6 instead of 32. This keeps full-length writes, full-length reads and the forced NAK on the I2C read limit to a few handshakes each. It also lets received counts just above the limit be tried cheaply. A bus-master model with random latency records every operation and answers with programmed ACK/NAK and read data. This exposes the stall during byte done, the count boundaries, early termination by the last-byte request and NAKs at every position.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    BOP_NONE   = 3'd0,
    BOP_START  = 3'd1,
    BOP_RSTART = 3'd2,
    BOP_WRITE  = 3'd3,
    BOP_READ   = 3'd4,
    BOP_STOP   = 3'd5
  } bus_op_e;

  typedef enum logic [1:0] {
    XM_SMB_WR = 2'd0,
    XM_SMB_RD = 2'd1,
    XM_I2C_RD = 2'd2,
    XM_I2C_WR = 2'd3
  } xfer_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR_W, ST_CMD, ST_CNT_W, ST_DATA_W,
    ST_RSTART, ST_ADDR_R, ST_CNT_R, ST_DATA_R, ST_WAIT_BD, ST_STOP
  } seq_state_e;

  // A block length outside 1..maxl is not accepted
  function automatic logic len_bad(input logic [BYTE_W-1:0] v, input int unsigned maxl);
    return (v == '0) || (32'(v) > maxl);
  endfunction

endpackage

// File: rtl/smbblk_bytecnt.sv
module smbblk_bytecnt
  import smbblk_pkg::*;
#(
  parameter int MAXLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              tot_ld_i,
  input  logic [BYTE_W-1:0] tot_din_i,
  output logic [BYTE_W-1:0] total_o,
  output logic              reached_o,
  output logic              next_last_o,
  output logic              cap_last_o
);

  localparam int CW = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] LAST_C = CW'(MAXLEN - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] tot_q, tot_d;
  logic              cnt_en, tot_en;
  logic [BYTE_W:0]   cnt_ext;

  assign cnt_en = clr_i | inc_i;
  assign tot_en = tot_ld_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
    tot_d = tot_din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tot_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (tot_en) tot_q <= tot_d;
    end
  end

  assign cnt_ext     = (BYTE_W+1)'(cnt_q);
  assign total_o     = tot_q;
  assign reached_o   = (cnt_ext == {1'b0, tot_q});
  assign next_last_o = ((cnt_ext + 1'b1) == {1'b0, tot_q});
  assign cap_last_o  = (cnt_q == LAST_C);

endmodule

// File: rtl/smbblk_flags.sv
module smbblk_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic bd_set_i,
  input  logic bd_clr_i,
  input  logic last_set_i,
  input  logic end_i,
  output logic byte_done_o,
  output logic last_o
);

  logic bd_q, bd_d, last_q, last_d;
  logic bd_en, last_en;

  assign bd_en   = bd_set_i | bd_clr_i;
  assign last_en = last_set_i | end_i;

  always_comb begin
    bd_d   = bd_set_i;
    last_d = last_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bd_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (bd_en)   bd_q   <= bd_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign byte_done_o = bd_q;
  assign last_o      = last_q;

endmodule

// File: rtl/smbblk_seq.sv
module smbblk_seq
  import smbblk_pkg::*;
#(
  parameter int MAXLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [6:0]        addr_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] dat0_i,
  input  logic [BYTE_W-1:0] dat1_i,
  input  logic              blk_wr_i,
  input  logic [BYTE_W-1:0] blk_wdata_i,
  input  logic              bd_q_i,
  input  logic              last_q_i,
  input  logic              reached_i,
  input  logic              next_last_i,
  input  logic              cap_last_i,
  input  logic [BYTE_W-1:0] total_i,
  output logic              bd_set_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              tot_ld_o,
  output logic [BYTE_W-1:0] tot_din_o,
  output logic              end_o,
  output logic              busy_o,
  output logic              intr_o,
  output logic              dev_err_o,
  output logic [BYTE_W-1:0] blk_o,
  output logic              m_req_o,
  output bus_op_e           m_op_o,
  output logic [BYTE_W-1:0] m_wdata_o,
  output logic              m_nak_o,
  input  logic              m_done_i,
  input  logic              m_ack_i,
  input  logic [BYTE_W-1:0] m_rdata_i
);

  seq_state_e        state_q, state_d;
  xfer_mode_e        mode_q, mode_d;
  logic [6:0]        addr_q, addr_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [BYTE_W-1:0] blk_q, blk_d;
  logic              fail_q, fail_d;
  logic              naks_q, naks_d;
  logic              busy_q, busy_d;
  logic              intr_q, intr_d;
  logic              err_q, err_d;
  logic              rd_nak;

  assign rd_nak = last_q_i | cap_last_i | ((mode_q == XM_SMB_RD) & next_last_i);

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    addr_d    = addr_q;
    cmd_d     = cmd_q;
    fail_d    = fail_q;
    naks_d    = naks_q;
    busy_d    = busy_q;
    intr_d    = intr_q;
    err_d     = err_q;
    blk_d     = blk_wr_i ? blk_wdata_i : blk_q;
    m_req_o   = 1'b0;
    m_op_o    = BOP_NONE;
    m_wdata_o = '0;
    m_nak_o   = 1'b0;
    bd_set_o  = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    tot_ld_o  = 1'b0;
    tot_din_o = dat0_i;
    end_o     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          intr_d = 1'b0;
          err_d  = 1'b0;
          if ((mode_i == XM_I2C_WR) ||
              ((mode_i == XM_SMB_WR) && len_bad(dat0_i, MAXLEN))) begin
            err_d = 1'b1;
          end else begin
            busy_d    = 1'b1;
            fail_d    = 1'b0;
            naks_d    = 1'b0;
            mode_d    = xfer_mode_e'(mode_i);
            addr_d    = addr_i;
            cmd_d     = (mode_i == XM_I2C_RD) ? dat1_i : cmd_i;
            cnt_clr_o = 1'b1;
            tot_ld_o  = 1'b1;
            state_d   = ST_START;
          end
        end
      end
      ST_START: begin
        m_req_o = 1'b1;
        m_op_o  = BOP_START;
        if (m_done_i) state_d = ST_ADDR_W;
      end
      ST_ADDR_W, ST_CMD, ST_CNT_W, ST_DATA_W, ST_ADDR_R: begin
        m_req_o = 1'b1;
        m_op_o  = BOP_WRITE;
        unique case (state_q)
          ST_ADDR_W: m_wdata_o = {addr_q, 1'b0};
          ST_CMD:    m_wdata_o = cmd_q;
          ST_CNT_W:  m_wdata_o = total_i;
          ST_DATA_W: m_wdata_o = blk_q;
          default:   m_wdata_o = {addr_q, 1'b1};
        endcase
        if (m_done_i) begin
          if (!m_ack_i) begin
            fail_d  = 1'b1;
            state_d = ST_STOP;
          end else begin
            unique case (state_q)
              ST_ADDR_W: state_d = ST_CMD;
              ST_CMD:    state_d = (mode_q == XM_SMB_WR) ? ST_CNT_W : ST_RSTART;
              ST_CNT_W:  state_d = ST_DATA_W;
              ST_DATA_W: begin
                cnt_inc_o = 1'b1;
                bd_set_o  = 1'b1;
                state_d   = ST_WAIT_BD;
              end
              default:   state_d = (mode_q == XM_SMB_RD) ? ST_CNT_R : ST_DATA_R;
            endcase
          end
        end
      end
      ST_RSTART: begin
        m_req_o = 1'b1;
        m_op_o  = BOP_RSTART;
        if (m_done_i) state_d = ST_ADDR_R;
      end
      ST_CNT_R: begin
        m_req_o = 1'b1;
        m_op_o  = BOP_READ;
        if (m_done_i) begin
          tot_ld_o  = 1'b1;
          tot_din_o = m_rdata_i;
          if (len_bad(m_rdata_i, MAXLEN)) begin
            fail_d  = 1'b1;
            state_d = ST_STOP;
          end else begin
            state_d = ST_DATA_R;
          end
        end
      end
      ST_DATA_R: begin
        m_req_o = 1'b1;
        m_op_o  = BOP_READ;
        m_nak_o = rd_nak;
        if (m_done_i) begin
          blk_d     = m_rdata_i;
          cnt_inc_o = 1'b1;
          bd_set_o  = 1'b1;
          naks_d    = rd_nak;
          state_d   = ST_WAIT_BD;
        end
      end
      ST_WAIT_BD: begin
        if (!bd_q_i) begin
          if (mode_q == XM_SMB_WR) state_d = reached_i ? ST_STOP : ST_DATA_W;
          else                     state_d = naks_q ? ST_STOP : ST_DATA_R;
        end
      end
      ST_STOP: begin
        m_req_o = 1'b1;
        m_op_o  = BOP_STOP;
        if (m_done_i) begin
          busy_d  = 1'b0;
          end_o   = 1'b1;
          err_d   = fail_q;
          intr_d  = ~fail_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= XM_SMB_WR;
      addr_q  <= '0;
      cmd_q   <= '0;
      blk_q   <= '0;
      fail_q  <= 1'b0;
      naks_q  <= 1'b0;
      busy_q  <= 1'b0;
      intr_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      addr_q  <= addr_d;
      cmd_q   <= cmd_d;
      blk_q   <= blk_d;
      fail_q  <= fail_d;
      naks_q  <= naks_d;
      busy_q  <= busy_d;
      intr_q  <= intr_d;
      err_q   <= err_d;
    end
  end

  assign busy_o    = busy_q;
  assign intr_o    = intr_q;
  assign dev_err_o = err_q;
  assign blk_o     = blk_q;

endmodule

// File: rtl/smbblk_engine.sv
module smbblk_engine
  import smbblk_pkg::*;
#(
  parameter int MAXLEN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic [6:0] addr_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] dat0_i,
  input  logic [7:0] dat1_i,
  input  logic       blk_wr_i,
  input  logic [7:0] blk_wdata_i,
  input  logic       bd_clr_i,
  input  logic       last_byte_i,
  output logic       busy_o,
  output logic       intr_o,
  output logic       dev_err_o,
  output logic       byte_done_o,
  output logic [7:0] blk_rdata_o,
  output logic [7:0] count_o,
  output logic       m_req_o,
  output logic [2:0] m_op_o,
  output logic [7:0] m_wdata_o,
  output logic       m_nak_o,
  input  logic       m_done_i,
  input  logic       m_ack_i,
  input  logic [7:0] m_rdata_i
);

  logic              bd_set, cnt_clr, cnt_inc, tot_ld, end_x;
  logic              bd_q, last_q, reached, next_last, cap_last;
  logic [BYTE_W-1:0] tot_din, total;
  bus_op_e           op;

  smbblk_bytecnt #(.MAXLEN(MAXLEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .tot_ld_i(tot_ld), .tot_din_i(tot_din), .total_o(total),
    .reached_o(reached), .next_last_o(next_last), .cap_last_o(cap_last)
  );

  smbblk_flags u_flags (
    .clk(clk), .rst_n(rst_n), .bd_set_i(bd_set), .bd_clr_i(bd_clr_i),
    .last_set_i(last_byte_i), .end_i(end_x),
    .byte_done_o(bd_q), .last_o(last_q)
  );

  smbblk_seq #(.MAXLEN(MAXLEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .cmd_i(cmd_i), .dat0_i(dat0_i), .dat1_i(dat1_i),
    .blk_wr_i(blk_wr_i), .blk_wdata_i(blk_wdata_i),
    .bd_q_i(bd_q), .last_q_i(last_q), .reached_i(reached),
    .next_last_i(next_last), .cap_last_i(cap_last), .total_i(total),
    .bd_set_o(bd_set), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .tot_ld_o(tot_ld), .tot_din_o(tot_din), .end_o(end_x),
    .busy_o(busy_o), .intr_o(intr_o), .dev_err_o(dev_err_o),
    .blk_o(blk_rdata_o), .m_req_o(m_req_o), .m_op_o(op),
    .m_wdata_o(m_wdata_o), .m_nak_o(m_nak_o),
    .m_done_i(m_done_i), .m_ack_i(m_ack_i), .m_rdata_i(m_rdata_i)
  );

  assign m_op_o      = op;
  assign byte_done_o = bd_q;
  assign count_o     = total;

endmodule

// File: rtl/smbblk_engine_chk.sv
module smbblk_engine_chk
  import smbblk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       intr_o,
  input logic       dev_err_o,
  input logic       byte_done_o,
  input logic       m_req_o,
  input logic [2:0] m_op_o,
  input logic       m_done_i
);

  // R1
  intr_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_o) |-> ($past(m_req_o && (m_op_o == BOP_STOP) && m_done_i) && !busy_o));

  // R2
  bd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> !m_req_o);

  // R2
  bd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_done_o) |-> $past(m_done_i));

  // R7
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !m_req_o);

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_err_o) |-> !busy_o);

  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(intr_o && dev_err_o));

endmodule

bind smbblk_engine smbblk_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .intr_o(intr_o),
  .dev_err_o(dev_err_o), .byte_done_o(byte_done_o), .m_req_o(m_req_o),
  .m_op_o(m_op_o), .m_done_i(m_done_i)
);

// File: tb/tb_smbblk_engine.sv
module tb_smbblk_engine;

  localparam int MAXL = 6;
  localparam logic [2:0] OP_START = 3'd1, OP_RSTART = 3'd2, OP_WRITE = 3'd3,
                         OP_READ = 3'd4, OP_STOP = 3'd5;

  logic clk, rst_n, start_i, blk_wr_i, bd_clr_i, last_byte_i;
  logic [1:0] mode_i;
  logic [6:0] addr_i;
  logic [7:0] cmd_i, dat0_i, dat1_i, blk_wdata_i;
  logic busy_o, intr_o, dev_err_o, byte_done_o, m_req_o, m_nak_o;
  logic [7:0] blk_rdata_o, count_o, m_wdata_o;
  logic [2:0] m_op_o;
  logic m_done_i, m_ack_i;
  logic [7:0] m_rdata_i;

  smbblk_engine #(.MAXLEN(MAXL)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .cmd_i(cmd_i), .dat0_i(dat0_i), .dat1_i(dat1_i),
    .blk_wr_i(blk_wr_i), .blk_wdata_i(blk_wdata_i), .bd_clr_i(bd_clr_i),
    .last_byte_i(last_byte_i), .busy_o(busy_o), .intr_o(intr_o),
    .dev_err_o(dev_err_o), .byte_done_o(byte_done_o), .blk_rdata_o(blk_rdata_o),
    .count_o(count_o), .m_req_o(m_req_o), .m_op_o(m_op_o),
    .m_wdata_o(m_wdata_o), .m_nak_o(m_nak_o), .m_done_i(m_done_i),
    .m_ack_i(m_ack_i), .m_rdata_i(m_rdata_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk, n_bad;
  logic [2:0] l_op[128], e_op[128];
  logic [7:0] l_dat[128], e_dat[128];
  logic       l_nak[128], e_nak[128];
  int n_log, n_exp, ridx, wcnt, nak_at, exp_n, k_hs;
  bit exp_err;
  logic [7:0] rd_src[64], wr_src[64], got[64];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // bus master model: random latency, programmed ACK/NAK and read data
  initial begin
    m_done_i = 1'b0; m_ack_i = 1'b1; m_rdata_i = 8'h00;
    forever begin
      @(negedge clk);
      if (m_req_o) begin
        repeat ($urandom % 3) @(negedge clk);
        if (n_log < 128) begin
          l_op[n_log] = m_op_o; l_dat[n_log] = m_wdata_o; l_nak[n_log] = m_nak_o;
        end
        m_ack_i = 1'b1;
        if (m_op_o == OP_WRITE) begin
          if (wcnt == nak_at) m_ack_i = 1'b0;
          wcnt++;
        end
        if (m_op_o == OP_READ) begin
          m_rdata_i = rd_src[ridx % 64];
          ridx++;
        end
        n_log++;
        m_done_i = 1'b1;
        @(negedge clk);
        m_done_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic push(input logic [2:0] op, input logic [7:0] d, input logic nk);
    e_op[n_exp] = op; e_dat[n_exp] = d; e_nak[n_exp] = nk; n_exp++;
  endtask

  task automatic build_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] cnt);
    push(OP_START, 0, 0);
    for (int i = 0; i < 3 + int'(cnt); i++) begin
      logic [7:0] v;
      v = (i == 0) ? {a, 1'b0} : (i == 1) ? c : (i == 2) ? cnt : wr_src[i-3];
      push(OP_WRITE, v, 0);
      if (i == nak_at) break;
    end
    push(OP_STOP, 0, 0);
    exp_err = (nak_at >= 0);
    exp_n   = (nak_at < 0) ? int'(cnt) : ((nak_at > 3) ? nak_at - 3 : 0);
  endtask

  task automatic build_read(input bit i2c, input logic [6:0] a, input logic [7:0] c, input int last_at);
    int lim;
    exp_n = 0; exp_err = 1'b1;
    push(OP_START, 0, 0);
    push(OP_WRITE, {a, 1'b0}, 0);
    if (nak_at == 0) begin push(OP_STOP, 0, 0); return; end
    push(OP_WRITE, c, 0);
    if (nak_at == 1) begin push(OP_STOP, 0, 0); return; end
    push(OP_RSTART, 0, 0);
    push(OP_WRITE, {a, 1'b1}, 0);
    if (nak_at == 2) begin push(OP_STOP, 0, 0); return; end
    if (!i2c) begin
      push(OP_READ, 0, 0);
      if (rd_src[0] == 0 || int'(rd_src[0]) > MAXL) begin push(OP_STOP, 0, 0); return; end
      lim = int'(rd_src[0]);
    end else lim = MAXL;
    exp_n = lim;
    if (last_at >= 0 && last_at + 1 < lim) exp_n = last_at + 1;
    for (int i = 0; i < exp_n; i++) push(OP_READ, 0, (i == exp_n - 1));
    push(OP_STOP, 0, 0);
    exp_err = 1'b0;
  endtask

  // software side: one transfer with handshakes
  task automatic xfer(input logic [1:0] md, input logic [7:0] d0, input int last_at,
                      input bit inject, input string rq);
    bit rej, rd;
    int guard;
    n_log = 0; ridx = 0; wcnt = 0; n_exp = 0; k_hs = 0;
    addr_i = 7'($urandom); cmd_i = 8'($urandom); dat1_i = 8'($urandom);
    rej = (md == 2'd3) || (md == 2'd0 && (d0 == 0 || int'(d0) > MAXL));
    rd  = (md != 2'd0);
    if (rej) begin exp_err = 1'b1; exp_n = 0; end
    else if (md == 2'd0) build_write(addr_i, cmd_i, d0);
    else build_read(md == 2'd2, addr_i, (md == 2'd2) ? dat1_i : cmd_i, last_at);
    @(negedge clk);
    if (md == 2'd0) begin blk_wr_i = 1'b1; blk_wdata_i = wr_src[0]; end
    if (rd && last_at == 0) last_byte_i = 1'b1;
    @(negedge clk);
    blk_wr_i = 1'b0; last_byte_i = 1'b0;
    mode_i = md; dat0_i = d0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 4000) begin chk(1'b0, {rq, " hang"}, guard, 0); break; end
      if (!busy_o) break;
      if (byte_done_o) begin
        repeat ($urandom % 4) begin
          @(negedge clk);
          // R2: stalled while byte done is pending
          chk(!m_req_o, "R2 stall", m_req_o, 0);
        end
        if (!rd) begin
          k_hs++;
          if (k_hs < int'(d0)) begin blk_wr_i = 1'b1; blk_wdata_i = wr_src[k_hs]; end
        end else begin
          got[k_hs] = blk_rdata_o;
          k_hs++;
          if (k_hs == last_at) last_byte_i = 1'b1;
        end
        if (inject && k_hs == 1) begin start_i = 1'b1; mode_i = 2'd1; end
        bd_clr_i = 1'b1;
        @(negedge clk);
        bd_clr_i = 1'b0; blk_wr_i = 1'b0; last_byte_i = 1'b0; start_i = 1'b0;
      end
    end
    chk(n_log == n_exp, {rq, " op count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++)
      chk(l_op[i] == e_op[i] && l_dat[i] == e_dat[i] && l_nak[i] == e_nak[i],
          {rq, " op"}, int'({l_op[i], l_dat[i], l_nak[i]}), int'({e_op[i], e_dat[i], e_nak[i]}));
    chk(k_hs == exp_n, {rq, " R2 handshakes"}, k_hs, exp_n);
    if (md == 2'd1 || md == 2'd2)
      for (int i = 0; i < exp_n && i < k_hs; i++)
        chk(got[i] == rd_src[(md == 2'd1) ? i + 1 : i], {rq, " R3 data"}, got[i],
            rd_src[(md == 2'd1) ? i + 1 : i]);
    if (md == 2'd1 && nak_at < 0)
      chk(count_o == rd_src[0], {rq, " R3 count"}, count_o, rd_src[0]);
    // R11: fresh status, exactly one outcome
    chk(dev_err_o == exp_err && intr_o == !exp_err && !busy_o, {rq, " R11 status"},
        int'({busy_o, intr_o, dev_err_o}), int'({1'b0, !exp_err, exp_err}));
    nak_at = -1;
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) begin
      wr_src[i] = 8'($urandom); rd_src[i] = 8'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    n_chk = 0; n_bad = 0; nak_at = -1;
    rst_n = 1'b0; start_i = 0; mode_i = 0; addr_i = 0; cmd_i = 0; dat0_i = 0;
    dat1_i = 0; blk_wr_i = 0; blk_wdata_i = 0; bd_clr_i = 0; last_byte_i = 0;
    n_log = 0;
    repeat (3) @(negedge clk);
    // R10
    chk(!busy_o && !intr_o && !dev_err_o && !byte_done_o && !m_req_o, "R10 reset",
        int'({busy_o, intr_o, dev_err_o, byte_done_o, m_req_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(); xfer(2'd0, 8'd3, -1, 0, "R1 write3");
    fill(); xfer(2'd0, 8'(MAXL), -1, 0, "R1 writemax");
    fill(); nak_at = 4; xfer(2'd0, 8'd4, -1, 0, "R8 nak data");
    fill(); nak_at = 0; xfer(2'd0, 8'd2, -1, 0, "R8 nak addr");
    fill(); xfer(2'd0, 8'd0, -1, 0, "R7 count0");
    fill(); xfer(2'd0, 8'(MAXL + 1), -1, 0, "R7 countbig");
    fill(); xfer(2'd3, 8'd2, -1, 0, "R7 i2cwrite");
    fill(); rd_src[0] = 8'd4; xfer(2'd1, 8'd0, -1, 0, "R3 read4");
    fill(); rd_src[0] = 8'd1; xfer(2'd1, 8'd0, -1, 0, "R3 read1");
    fill(); rd_src[0] = 8'd0; xfer(2'd1, 8'd0, -1, 0, "R4 cnt0");
    fill(); rd_src[0] = 8'(MAXL + 1); xfer(2'd1, 8'd0, -1, 0, "R4 cntbig");
    fill(); rd_src[0] = 8'd5; xfer(2'd1, 8'd0, 2, 0, "R6 early");
    fill(); nak_at = 2; rd_src[0] = 8'd3; xfer(2'd1, 8'd0, -1, 0, "R8 nak raddr");
    fill(); xfer(2'd2, 8'd0, 0, 0, "R5 one");
    fill(); xfer(2'd2, 8'd0, 3, 0, "R5 four");
    fill(); xfer(2'd2, 8'd0, -1, 0, "R5 cap");
    fill(); xfer(2'd0, 8'd3, -1, 1, "R9 inject");

    for (int it = 0; it < 40; it++) begin
      int md, la;
      fill();
      md = $urandom % 3;
      la = -1;
      if (md == 0) begin
        int c;
        c = 1 + $urandom % MAXL;
        if ($urandom % 5 == 0) nak_at = $urandom % (3 + c);
        xfer(2'd0, 8'(c), -1, 0, "R1 rand");
      end else if (md == 1) begin
        rd_src[0] = 8'($urandom % (MAXL + 2));
        if ($urandom % 4 == 0) la = $urandom % (MAXL + 1);
        if ($urandom % 6 == 0) nak_at = $urandom % 3;
        xfer(2'd1, 8'd0, la, 0, "R3 rand");
      end else begin
        if ($urandom % 5 != 0) la = $urandom % (MAXL + 2);
        xfer(2'd2, 8'd0, la, 0, "R5 rand");
      end
    end
    finish_run();
  end

endmodule